// File: doc/BRIEF.md
# SAR Converter Serial Port Model

This block models the device end of the serial link of a multichannel successive-approximation converter running without a busy indicator. A host drives the conversion-start line, the serial clock and the configuration data line. The block answers on a serial data line that comes with its own drive enable, so a pad or a bus model can turn it into a three-state pin. A rising edge on the conversion-start line starts an internal timer that stands in for the conversion time. When the timer expires, a single-cycle end-of-conversion event samples one channel of a parallel sample bus. That value is the "converted" result. Optionally, the configuration that produced the result is appended after it.

End of conversion is the only moment at which anything moves. At that event the output shift register is reloaded, so any unread bits are lost. A configuration word that arrived on the data input is accepted only if it is complete. Accepted words pass through a two-deep pipeline, so a word written in one phase shapes the result read two phases later. The first three results after reset carry no valid data and are driven as all ones.

All three host inputs are asynchronous to `clk` and pass through a two-stage synchronizer. The serial link is paced by the host, and the sample bus is read at end of conversion, so neither has a valid/ready handshake or back-pressure. The host simply must not toggle the serial clock faster than the system clock can resolve its edges.

Top module: `sar_serial_port`

## Requirements
- R1: After reset, and until the first end of conversion, `sdo_en_o` stays low whatever the host does on the serial lines.
- R2: A rising edge on `cnv_i` while no conversion is running starts one. End of conversion follows CONV_CYCLES clocks later. A further rising edge during a running conversion neither restarts nor extends it.
- R3: After end of conversion, while `cnv_i` is low, `sdo_o` is driven with the result MSB. Each falling `sck_i` edge then presents the next lower bit.
- R4: When the configuration readback bit (bit 12) was clear, the drive enable drops after 16 falling edges. When it was set, the drive enable drops after 30 falling edges, and the 14 configuration bits follow the result, MSB first.
- R5: While `cnv_i` is high, `sdo_en_o` is low.
- R6: `din_i` is captured on rising `sck_i` edges while `cnv_i` is low, MSB first, and only the first 14 bits of a phase are kept. The word is accepted at end of conversion only if its write-enable bit (bit 13) is set.
- R7: A word of fewer than 14 bits at end of conversion is discarded, and so is a word with bit 13 clear. The previous configuration stays in force.
- R8: End of conversion reloads the output even if the previous result was only partly shifted out. The next read starts at the MSB of the newest result.
- R9: A word accepted at end of conversion k becomes the active configuration at end of conversion k+1. It governs the result loaded at end of conversion k+2.
- R10: The results loaded at the first three ends of conversion after reset are all ones. A configuration word written before the first end of conversion is ignored.
- R11: A valid result equals the sample bus slice selected by configuration bits [2:0], channel c occupying bits [16c+15:16c], as it stood at end of conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnv_i | input | 1 | Conversion start, active on its rising edge; low selects the serial port |
| sck_i | input | 1 | Serial clock from the host, idles low |
| din_i | input | 1 | Configuration data from the host |
| sample_i | input | NCH*RES_W | Parallel values, one slice per channel, sampled at end of conversion |
| sdo_o | output | 1 | Serial result and readback data |
| sdo_en_o | output | 1 | Drive enable for `sdo_o` (low means high impedance) |

## Verification
Every host edge reaches the logic through two synchronizer flops and one edge register, so its effect on `sdo_o` or `sdo_en_o` shows up about three clocks later. The bench holds each serial clock level for five clocks and waits six clocks after lowering the conversion line before it looks. It samples at the falling clock edge, just before the next rising serial clock edge. End of conversion lands about CONV_CYCLES+3 clocks after the rising edge of the conversion line. The bench keeps the line high for CONV_CYCLES+12 clocks, so a restarted timer would still be running when reading resumes and would show up as wrong data. A bench model advances its own configuration pipeline and its count of ends of conversion once per phase.

// File: rtl/sar_port_pkg.sv
package sar_port_pkg;
  localparam int CFG_W = 14;

  // Configuration word, MSB first on the wire. Bit 13 is write enable, bit 12 is readback.
  typedef struct packed {
    logic       wr_en;
    logic       readback;
    logic [8:0] spare;
    logic [2:0] chan;
  } cfg_t;
endpackage

// File: rtl/sar_port_sync.sv
module sar_port_sync #(
  parameter int             W       = 3,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stage[g] <= RST_VAL;
      else if (g == 0) stage[g] <= d;
      else stage[g] <= stage[(g == 0) ? 0 : g-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/sar_port_timer.sv
module sar_port_timer #(
  parameter int CONV_CYCLES = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic eoc
);
  localparam int CW = $clog2(CONV_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CONV_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      eoc  <= 1'b0;
      cnt  <= '0;
    end else begin
      eoc <= 1'b0;
      if (busy) begin
        if (cnt == '0) begin
          busy <= 1'b0;
          eoc  <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (start) begin
        busy <= 1'b1;
        cnt  <= LAST;
      end
    end
  end
endmodule

// File: rtl/sar_port_cfg_in.sv
module sar_port_cfg_in
  import sar_port_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sck_rise,
  input  logic cnv_lvl,
  input  logic din,
  input  logic eoc,
  input  logic accept,
  output cfg_t act_cfg
);
  localparam int NBW = $clog2(CFG_W + 1);
  localparam logic [NBW-1:0] FULL = NBW'(CFG_W);

  logic [CFG_W-1:0] shreg;
  logic [NBW-1:0]   nbits;
  cfg_t             pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg   <= '0;
      nbits   <= '0;
      pend    <= '0;
      act_cfg <= '0;
    end else if (eoc) begin
      // The pending word moves to active; a complete, write-enabled word becomes pending.
      if (nbits == FULL && shreg[CFG_W-1] && accept) pend <= cfg_t'(shreg);
      act_cfg <= pend;
      nbits   <= '0;
    end else if (sck_rise && !cnv_lvl && nbits != FULL) begin
      shreg <= {shreg[CFG_W-2:0], din};
      nbits <= nbits + 1'b1;
    end
  end
endmodule

// File: rtl/sar_port_dout.sv
module sar_port_dout #(
  parameter int TOT = 30,
  parameter int LW  = $clog2(TOT + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           eoc,
  input  logic [TOT-1:0] load_word,
  input  logic [LW-1:0]  load_len,
  input  logic           sck_fall,
  input  logic           cnv_lvl,
  output logic           sdo,
  output logic           sdo_en
);
  logic [TOT-1:0] shreg;
  logic [LW-1:0]  remain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg  <= '0;
      remain <= '0;
    end else if (eoc) begin
      shreg  <= load_word;
      remain <= load_len;
    end else if (sck_fall && !cnv_lvl && remain != '0) begin
      shreg  <= {shreg[TOT-2:0], 1'b0};
      remain <= remain - 1'b1;
    end
  end

  assign sdo    = shreg[TOT-1];
  assign sdo_en = !cnv_lvl && (remain != '0);
endmodule

// File: rtl/sar_serial_port.sv
module sar_serial_port
  import sar_port_pkg::*;
#(
  parameter int CONV_CYCLES = 50,
  parameter int NCH         = 8,
  parameter int RES_W       = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cnv_i,
  input  logic                 sck_i,
  input  logic                 din_i,
  input  logic [NCH*RES_W-1:0] sample_i,
  output logic                 sdo_o,
  output logic                 sdo_en_o
);
  localparam int TOT   = RES_W + CFG_W;
  localparam int LW    = $clog2(TOT + 1);
  localparam int SEL_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic cnv_s, sck_s, din_s;
  logic cnv_q, sck_q;
  logic cnv_rise, sck_rise, sck_fall;
  logic busy, eoc;
  logic [1:0] eoc_cnt;
  cfg_t act_cfg;
  logic [RES_W-1:0] samples [NCH];
  logic [RES_W-1:0] result;
  logic [TOT-1:0]   load_word;
  logic [LW-1:0]    load_len;

  // The conversion line resets high so that a host holding it high through reset sees no edge.
  sar_port_sync #(.W(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({cnv_i, sck_i, din_i}),
    .q({cnv_s, sck_s, din_s})
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnv_q <= 1'b1;
      sck_q <= 1'b0;
    end else begin
      cnv_q <= cnv_s;
      sck_q <= sck_s;
    end
  end

  assign cnv_rise = cnv_s & ~cnv_q;
  assign sck_rise = sck_s & ~sck_q;
  assign sck_fall = ~sck_s & sck_q;

  sar_port_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(cnv_rise), .busy(busy), .eoc(eoc)
  );

  // Number of ends of conversion seen since reset, saturating at three.
  always_ff @(posedge clk) begin
    if (!rst_n) eoc_cnt <= '0;
    else if (eoc && eoc_cnt != 2'd3) eoc_cnt <= eoc_cnt + 2'd1;
  end

  sar_port_cfg_in u_cfg (
    .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .cnv_lvl(cnv_s),
    .din(din_s), .eoc(eoc), .accept(eoc_cnt != 2'd0), .act_cfg(act_cfg)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    assign samples[c] = sample_i[c*RES_W +: RES_W];
  end

  assign result    = (eoc_cnt == 2'd3) ? samples[act_cfg.chan[SEL_W-1:0]] : '1;
  assign load_word = {result, act_cfg};
  assign load_len  = act_cfg.readback ? LW'(TOT) : LW'(RES_W);

  sar_port_dout #(.TOT(TOT), .LW(LW)) u_dout (
    .clk(clk), .rst_n(rst_n), .eoc(eoc), .load_word(load_word),
    .load_len(load_len), .sck_fall(sck_fall), .cnv_lvl(cnv_s),
    .sdo(sdo_o), .sdo_en(sdo_en_o)
  );
endmodule

// File: rtl/sar_serial_port_chk.sv
module sar_serial_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cnv_s,
  input logic       sck_fall,
  input logic       busy,
  input logic       eoc,
  input logic [1:0] eoc_cnt,
  input logic       sdo_o,
  input logic       sdo_en_o
);
  p_hiz_cnv_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_s |-> !sdo_en_o);

  p_eoc_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |=> !eoc);

  p_eoc_ends_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> eoc);

  p_eoc_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |-> !busy);

  p_drive_after_eoc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |=> (sdo_en_o == !cnv_s));

  p_sdo_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!eoc && !sck_fall) |=> $stable(sdo_o));

  p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sdo_en_o) |-> ($past(sck_fall) || cnv_s));

  p_undef_ones_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc && eoc_cnt != 2'd3) |=> sdo_o);
endmodule

bind sar_serial_port sar_serial_port_chk u_chk (.*);

// File: tb/sar_serial_port_test.sv
module sar_serial_port_test;
  localparam int CONV  = 50;
  localparam int NCH   = 8;
  localparam int RES_W = 16;
  localparam int H     = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnv = 1'b1, sck = 1'b0, din = 1'b0;
  logic [NCH*RES_W-1:0] samp = '0;
  logic sdo, sdo_en;

  int nvec = 0, nerr = 0;
  bit done = 1'b0;

  // Bench model of the configuration pipeline and output word.
  logic [13:0] m_pend = '0, m_act = '0;
  logic [29:0] m_word = '0;
  int m_len = 0, m_eoc = 0;

  always #4 clk = ~clk;

  sar_serial_port #(.CONV_CYCLES(CONV), .NCH(NCH), .RES_W(RES_W)) uut (
    .clk(clk), .rst_n(rst_n), .cnv_i(cnv), .sck_i(sck), .din_i(din),
    .sample_i(samp), .sdo_o(sdo), .sdo_en_o(sdo_en)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] pick(input logic [NCH*RES_W-1:0] s, input logic [2:0] ch);
    return s[ch*16 +: 16];
  endfunction

  // One phase: read after the last end of conversion while writing w, then run a conversion.
  task automatic phase(input logic [13:0] w, input int nread, input bit glitch, input string tag);
    int nb;
    logic [13:0] new_act;
    cnv = 1'b0;
    wait_n(6);
    for (int i = 0; i < nread; i++) begin
      if (i < m_len)
        chk(sdo_en === 1'b1 && sdo === m_word[29-i], tag, {sdo_en, sdo}, {1'b1, m_word[29-i]});
      else
        chk(sdo_en === 1'b0, "R4 R1", sdo_en, 0);
      din = (i < 14) ? w[13-i] : 1'b0;
      wait_n(1);
      sck = 1'b1;
      wait_n(H);
      sck = 1'b0;
      wait_n(H);
    end
    chk(sdo_en === (nread < m_len), "R4", sdo_en, (nread < m_len));
    nb = (nread < 14) ? nread : 14;
    for (int c = 0; c < NCH; c++) samp[c*16 +: 16] = 16'($urandom);
    cnv = 1'b1;
    wait_n(3);
    chk(sdo_en === 1'b0, "R5", sdo_en, 0);
    if (glitch) begin
      // R2: a second rising edge during the conversion must not restart it
      wait_n(7);
      cnv = 1'b0;
      wait_n(4);
      cnv = 1'b1;
      wait_n(CONV + 12 - 14);
    end else begin
      wait_n(CONV + 9);
    end
    m_word  = {(m_eoc < 3) ? 16'hFFFF : pick(samp, m_act[2:0]), m_act};
    m_len   = m_act[12] ? 30 : 16;
    new_act = m_pend;
    if (nb == 14 && w[13] && m_eoc >= 1) m_pend = w;
    m_act = new_act;
    m_eoc++;
  endtask

  initial begin
    void'($urandom(32'd1977));
    wait_n(4);
    chk(sdo_en === 1'b0, "R1", sdo_en, 0);
    rst_n = 1'b1;
    wait_n(4);
    chk(sdo_en === 1'b0, "R1", sdo_en, 0);
    phase(14'h2005, 14, 1'b0, "R1 R10");   // written before first end of conversion: ignored
    phase(14'h2003, 16, 1'b0, "R3 R10");   // accepted, chan 3
    phase(14'h3006, 16, 1'b0, "R10");      // accepted, chan 6 with readback
    phase(14'h2001, 10, 1'b0, "R10");      // partial: discarded
    phase(14'h0002, 16, 1'b0, "R9 R11");   // first valid data, chan 3; bit13 clear: discarded
    phase(14'h2001, 30, 1'b0, "R4");       // readback appended
    phase(14'h0000, 30, 1'b1, "R7 R4");    // partial and disabled words left chan 6 in force
    phase(14'h0000, 5,  1'b0, "R2 R6");    // data from the glitched conversion; read cut short
    phase(14'h0000, 16, 1'b0, "R8 R6");    // newest result, chan 1 from the word written earlier
    for (int k = 0; k < 30; k++) begin
      int opts [7] = '{0, 5, 14, 16, 20, 30, 32};
      phase(14'($urandom), opts[$urandom_range(6)], 1'b0, "R11 R6 R9");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nvec++;
      nerr++;
      $display("FAIL R2 watchdog actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule